// File: doc/BRIEF.md
# Routed System Interrupt Controller

This block gathers 32 level-sensitive interrupt lines from the rest of the chip, remembers which of them are active in a pending register, and filters them through a disable mask that software manipulates with separate write-to-enable and write-to-disable words. Each line has a fixed processor priority level (1 to 15), or level 0 when the line is unused. The block finds the highest level among the lines that are both pending and enabled. It then drives that level, as a registered 4-bit value, to exactly one processor chosen by a target register, out of up to 16 processors.

Alongside the level, the block keeps one 16-bit level word per processor. A bit in that word is set or cleared whenever a line of that level is raised or dropped while the processor is the target. All words are exported for the per-processor logic to consume.

Software reaches the block over a 32-bit word-addressed bus with a single request strobe. Read data comes back one cycle after the request.

Top module: `sys_irq_router`

## Requirements
- R1: After reset every processor lane carries level 0, the target reads 0, pending reads 0x00000000 and the disable mask reads 0x004DFF80.
- R2: A write to word offset 2 clears the written bits of the disable mask. Bits set in the lock mask 0x4FB2007F are never changed by writes to offsets 2 or 3, and always read 0 in the disable mask.
- R3: A write to word offset 3 sets the written unlocked bits of the disable mask and clears the same bits in pending. A line that stays high does not set its pending bit again until it is dropped and raised anew.
- R4: The line-to-level table for lines 0..31 is 2,3,5,7,9,11,0,14, 3,5,7,9,11,13,12,12, 6,0,4,10,8,0,11,0, 0,0,0,0,15,0,15,0. A line with level 0 changes no state when raised or dropped, so pending can only hold bits of the valid mask 0x505DFFBF.
- R5: Raising a valid line sets its pending bit, and dropping it clears that bit. A read of word offset 0 returns pending with bit 31 forced to 0.
- R6: The delivered level is the largest table level over the bits of pending AND NOT disable. It is 0 when no such bit exists, or when disable bit 31 is set.
- R7: Word offset 4 reads and writes the target processor number. A written value keeps only its low 4 bits, so 0x25 selects processor 5.
- R8: Only the lane of the current target carries the level, and all other lanes carry 0. A lane changes one clock edge after the state it depends on.
- R9: Raising or dropping a valid line sets or clears the bit numbered by its level in the level word of the processor that is the target at that moment.
- R10: Reads of word offsets 5 to 7 return 0, and writes to them change nothing.
- R11: Read data is returned in the cycle after a read request and is 0 in any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt lines |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after a read |
| cpu_level_o | output | 64 | 4-bit level per processor, lane n at bits 4n+3..4n |
| tgt_word_o | output | 256 | 16-bit level word per processor, processor n at bits 16n+15..16n |

## Verification
A line change sampled at clock edge k shows in pending and in the level words right after edge k. It reaches the processor lane only after edge k+1. A register write at edge k likewise moves the lane after edge k+1. A read requested at edge k returns its data right after edge k. The bench drives every input at a falling edge. For line changes it waits two rising edges before sampling, and for writes it waits one extra rising edge. It samples only at the falling edge that follows, so each result is read in the cycle it is due.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NSRC   = 32;
    localparam int LVL_W  = 4;
    localparam int NLVL   = 1 << LVL_W;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    // Disable-mask bits that software writes cannot change.
    localparam logic [DATA_W-1:0] LOCK_MASK = 32'h4FB2007F;
    // Reset value of the disable mask.
    localparam logic [DATA_W-1:0] DIS_RESET = ~32'hFFB2007F;
    // Bit that gates all delivery when set in the disable mask.
    localparam int GLOBAL_OFF_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        OFF_PEND   = 3'd0,
        OFF_DIS    = 3'd1,
        OFF_ENABLE = 3'd2,
        OFF_SETDIS = 3'd3,
        OFF_TARGET = 3'd4
    } reg_off_e;

    // Fixed priority level of each interrupt line; 0 marks an unused line.
    function automatic logic [LVL_W-1:0] line_level(input int idx);
        logic [LVL_W-1:0] l;
        case (idx)
            0:  l = 4'd2;   1:  l = 4'd3;   2:  l = 4'd5;   3:  l = 4'd7;
            4:  l = 4'd9;   5:  l = 4'd11;  6:  l = 4'd0;   7:  l = 4'd14;
            8:  l = 4'd3;   9:  l = 4'd5;   10: l = 4'd7;   11: l = 4'd9;
            12: l = 4'd11;  13: l = 4'd13;  14: l = 4'd12;  15: l = 4'd12;
            16: l = 4'd6;   17: l = 4'd0;   18: l = 4'd4;   19: l = 4'd10;
            20: l = 4'd8;   21: l = 4'd0;   22: l = 4'd11;  23: l = 4'd0;
            28: l = 4'd15;  30: l = 4'd15;
            default: l = 4'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture
    import irq_router_pkg::*;
#(
    parameter int NCPU  = 16,
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          src_i,
    input  logic [CPU_W-1:0]         tgt_i,
    input  logic [NSRC-1:0]          pend_clr_i,
    output logic [NSRC-1:0]          pend_o,
    output logic [NCPU*NLVL-1:0]     word_o
);

    typedef struct packed {
        logic [NSRC-1:0]            src;
        logic [NSRC-1:0]            pend;
        logic [NCPU-1:0][NLVL-1:0]  word;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.src = src_i;
        for (int i = 0; i < NSRC; i++) begin
            if (line_level(i) != '0 && src_i[i] != cap_q.src[i]) begin
                cap_d.pend[i]                         = src_i[i];
                cap_d.word[tgt_i][line_level(i)]      = src_i[i];
            end
        end
        cap_d.pend = cap_d.pend & ~pend_clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pend_o = cap_q.pend;
    assign word_o = cap_q.word;

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_router_pkg::*;
#(
    parameter int NCPU  = 16,
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NSRC-1:0]    pend_i,
    output logic [NSRC-1:0]    dis_o,
    output logic [CPU_W-1:0]   tgt_o,
    output logic [NSRC-1:0]    pend_clr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [NSRC-1:0]   dis;
        logic [CPU_W-1:0]  tgt;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr, rd;
    logic [DATA_W-1:0] wmask;

    assign wr    = req_i && we_i;
    assign rd    = req_i && !we_i;
    assign wmask = wdata_i & ~LOCK_MASK;

    always_comb begin
        regs_d       = regs_q;
        regs_d.rdata = '0;
        pend_clr_o   = '0;
        if (wr) begin
            case (addr_i)
                OFF_ENABLE: regs_d.dis = regs_q.dis & ~wmask;
                OFF_SETDIS: begin
                    regs_d.dis = regs_q.dis | wmask;
                    pend_clr_o = wmask;
                end
                OFF_TARGET: regs_d.tgt = wdata_i[CPU_W-1:0];
                default: ;
            endcase
        end
        if (rd) begin
            case (addr_i)
                OFF_PEND:   regs_d.rdata = pend_i & ~(DATA_W'(1) << GLOBAL_OFF_BIT);
                OFF_DIS:    regs_d.rdata = regs_q.dis;
                OFF_TARGET: regs_d.rdata = DATA_W'(regs_q.tgt);
                default:    regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dis   <= DIS_RESET;
            regs_q.tgt   <= '0;
            regs_q.rdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dis_o   = regs_q.dis;
    assign tgt_o   = regs_q.tgt;
    assign rdata_o = regs_q.rdata;

endmodule

// File: rtl/irq_level_encode.sv
module irq_level_encode
    import irq_router_pkg::*;
(
    input  logic [NSRC-1:0]  pend_i,
    input  logic [NSRC-1:0]  dis_i,
    output logic [LVL_W-1:0] level_o
);

    logic [NSRC-1:0] live;

    always_comb begin
        live    = dis_i[GLOBAL_OFF_BIT] ? '0 : (pend_i & ~dis_i);
        level_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (live[i] && line_level(i) > level_o) begin
                level_o = line_level(i);
            end
        end
    end

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
    import irq_router_pkg::*;
#(
    parameter int NCPU  = 16,
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [31:0]            src_i,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [2:0]             addr_i,
    input  logic [31:0]            wdata_i,
    output logic [31:0]            rdata_o,
    output logic [NCPU*4-1:0]      cpu_level_o,
    output logic [NCPU*16-1:0]     tgt_word_o
);

    logic [NSRC-1:0]  pend, dis, pend_clr;
    logic [CPU_W-1:0] tgt;
    logic [LVL_W-1:0] top_level;

    logic [NCPU-1:0][LVL_W-1:0] lane_d, lane_q;

    irq_reg_file #(.NCPU(NCPU)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .we_i       (we_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .pend_i     (pend),
        .dis_o      (dis),
        .tgt_o      (tgt),
        .pend_clr_o (pend_clr),
        .rdata_o    (rdata_o)
    );

    irq_line_capture #(.NCPU(NCPU)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .tgt_i      (tgt),
        .pend_clr_i (pend_clr),
        .pend_o     (pend),
        .word_o     (tgt_word_o)
    );

    irq_level_encode u_enc (
        .pend_i  (pend),
        .dis_i   (dis),
        .level_o (top_level)
    );

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            lane_d[c] = (CPU_W'(c) == tgt) ? top_level : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign cpu_level_o = lane_q;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NCPU  = 16,
    localparam int CPU_W = $clog2(NCPU)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [2:0]        addr_i,
    input logic [31:0]       rdata_o,
    input logic [NCPU*4-1:0] cpu_level_o
);

    logic [NCPU-1:0] lane_nz;
    logic            rd;

    assign rd = req_i && !we_i;

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            lane_nz[c] = |cpu_level_o[c*4 +: 4];
        end
    end

    a_r8_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_nz));

    a_r5_pend_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd && addr_i == 3'd0 |=> !rdata_o[31]);

    a_r10_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd && addr_i > 3'd4 |=> rdata_o == '0);

    a_r7_target_width: assert property (@(posedge clk) disable iff (!rst_n)
        rd && addr_i == 3'd4 |=> rdata_o[31:CPU_W] == '0);

    a_r2_locked_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd && addr_i == 3'd1 |=> (rdata_o & LOCK_MASK) == '0);

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata_o == '0);

endmodule

bind sys_irq_router irq_router_chk #(.NCPU(NCPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .rdata_o     (rdata_o),
    .cpu_level_o (cpu_level_o)
);

// File: tb/tb_sys_irq_router.sv
module tb_sys_irq_router;

    localparam int NCPU = 16;
    localparam int NVEC = 14;
    localparam logic [31:0] VALID = 32'h505DFFBF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       src_i = '0;
    logic              req_i = 1'b0;
    logic              we_i = 1'b0;
    logic [2:0]        addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic [NCPU*4-1:0] cpu_level_o;
    logic [NCPU*16-1:0] tgt_word_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sys_irq_router #(.NCPU(NCPU)) dut (.*);

    // {line pattern, expected level at processor 0 with reset masks}
    localparam logic [35:0] VEC [NVEC] = '{
        {32'h00000001, 4'd2},  {32'h00000002, 4'd3},
        {32'h00000010, 4'd9},  {32'h00000021, 4'd11},
        {32'h00000040, 4'd0},  {32'h00000080, 4'd0},
        {32'h10000000, 4'd15}, {32'h00020000, 4'd0},
        {32'h00100000, 4'd8},  {32'h00200000, 4'd0},
        {32'h00400000, 4'd0},  {32'h00800000, 4'd0},
        {32'h00100003, 4'd8},  {32'h00000000, 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lane(input int c);
        return cpu_level_o[c*4 +: 4];
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src_i = s;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_after_write();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_i = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        chk("R1 lanes", {32'h0, cpu_level_o[31:0]} , '0);
        chk("R1 lanes hi", cpu_level_o[63:32], '0);
        rd(3'd1, v); chk("R1 disable", v, 32'h004DFF80);
        rd(3'd4, v); chk("R1 target", v, 32'h0);
        rd(3'd0, v); chk("R1 pending", v, 32'h0);

        // R4 R5 R6 table walk with reset masks
        for (int i = 0; i < NVEC; i++) begin
            set_src(VEC[i][35:4]);
            chk($sformatf("R6 vec%0d level", i), 32'(lane(0)), 32'(VEC[i][3:0]));
            rd(3'd0, v);
            chk($sformatf("R5 R4 vec%0d pending", i), v, VEC[i][35:4] & VALID);
        end

        // R4 unused line changes no state
        do_reset();
        set_src(32'h00000040);
        rd(3'd0, v); chk("R4 unused pending", v, 32'h0);
        chk("R4 unused word", 32'(tgt_word_o[15:0]), 32'h0);
        chk("R4 unused level", 32'(lane(0)), 32'h0);

        // R2 enable write and locked bits
        do_reset();
        wr(3'd2, 32'hFFFFFFFF);
        rd(3'd1, v); chk("R2 enable all", v, 32'h0);
        set_src(32'h00000080);
        chk("R2 line7 level", 32'(lane(0)), 32'd14);

        // R3 disable clears pending, held line stays cleared
        wr(3'd3, 32'h00000080);
        settle_after_write();
        chk("R3 level after disable", 32'(lane(0)), 32'h0);
        rd(3'd0, v); chk("R3 pending cleared", v, 32'h0);
        wr(3'd2, 32'h00000080);
        settle_after_write();
        chk("R3 re-enable no repend", 32'(lane(0)), 32'h0);
        wr(3'd3, 32'hFFFFFFFF);
        rd(3'd1, v); chk("R2 R3 lock on disable", v, 32'hB04DFF80);

        // R6 global off bit
        do_reset();
        set_src(32'h00000001);
        chk("R6 line0 level", 32'(lane(0)), 32'd2);
        wr(3'd3, 32'h80000000);
        settle_after_write();
        chk("R6 global off", 32'(lane(0)), 32'h0);
        wr(3'd2, 32'h80000000);
        settle_after_write();
        chk("R6 global back on", 32'(lane(0)), 32'd2);

        // R7 R8 R9 target routing
        do_reset();
        wr(3'd4, 32'h00000025);
        rd(3'd4, v); chk("R7 target trunc", v, 32'h5);
        set_src(32'h00000002);
        chk("R8 lane5 level", 32'(lane(5)), 32'd3);
        chk("R8 lane0 quiet", 32'(lane(0)), 32'h0);
        chk("R9 word5 set", 32'(tgt_word_o[5*16 +: 16]), 32'h0008);
        chk("R9 word0 untouched", 32'(tgt_word_o[15:0]), 32'h0);
        set_src(32'h00000000);
        chk("R9 word5 cleared", 32'(tgt_word_o[5*16 +: 16]), 32'h0);
        chk("R8 lane5 drop", 32'(lane(5)), 32'h0);

        // R10 unused offsets
        do_reset();
        wr(3'd5, 32'hFFFFFFFF);
        wr(3'd7, 32'hFFFFFFFF);
        rd(3'd5, v); chk("R10 read 5", v, 32'h0);
        rd(3'd6, v); chk("R10 read 6", v, 32'h0);
        rd(3'd1, v); chk("R10 disable unchanged", v, 32'h004DFF80);
        rd(3'd4, v); chk("R10 target unchanged", v, 32'h0);

        // R11 read data only after a read
        @(negedge clk);
        chk("R11 idle rdata", rdata_o, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule